// File: doc/BRIEF.md
# Region Descriptor Access Guard

This block sits beside a bus slave and decides, for every access that reaches it, whether the access may proceed. It holds a parameterised set of address-range descriptors. Each descriptor has an inclusive lower bound, an inclusive upper bound, a permission attribute and a valid flag. Every access carries an address, a read/write flag, a privilege flag and a master number. The access is checked against all descriptors at once. The decision comes back one clock later as a grant or a fault.

Software programs the descriptors through a word-addressed configuration port. Descriptor 0 is the safety net. Its bounds always span the whole address space and it is always valid. Its debugger permissions are fixed, so a debugger can never be locked out. Software can change only its core-side permissions, and only through a dedicated alternate register.

A global control word switches checking on or off. It also holds a sticky error flag. Each denied access updates a pair of error-detail registers with the faulting address and the access type.

Top module: `region_guard`

## Requirements
- R1: After reset the following hold.
  - The control word reads 0.
  - Descriptor 0 reads lower bound 0, upper bound all ones, attribute 0x3F and valid 1.
  - Every other descriptor reads 0 in all four words.
  - Both error-detail registers read 0.
- R2: Bit 0 of the control word enables checking. While it is 0, every access is granted, whatever the descriptors hold.
- R3: With checking enabled, an access is granted when at least one descriptor meets all of the following:
  - it is valid;
  - its lower bound is at or below the address;
  - its upper bound is at or above the address;
  - it permits the access.

  Overlapping descriptors combine by OR, so one granting descriptor is enough. Otherwise the access faults.
- R4: The attribute bits are:
  - bit 0: user read;
  - bit 1: user write;
  - bit 2: supervisor read;
  - bit 3: supervisor write;
  - bit 4: debugger read;
  - bit 5: debugger write.

  The debugger bits apply when the master number equals `DBG_MID`, regardless of privilege. For other masters, the privilege flag picks the user or supervisor pair.
- R5: A write to the lower-bound, upper-bound or attribute word of descriptor 1 or above clears that descriptor's valid flag. Bit 0 of a write to the valid word sets or clears the flag.
- R6: Descriptor 0 is protected.
  - Writes to any of its four descriptor words have no effect.
  - A write to the alternate register replaces only attribute bits 3:0. Its debugger bits stay 1 and its valid flag stays 1.
  - A debugger-master access is therefore never faulted.
- R7: Bounds are kept on a 2^`GRAN_LOG2` byte granule. The lower `GRAN_LOG2` bits of a stored lower bound read as 0, and those of a stored upper bound read as 1.
- R8: Every cycle with `acc_valid` high is followed, exactly one cycle later, by a cycle with `rsp_valid` high. `rsp_fault` is high only together with `rsp_valid`.
- R9: A faulted access has three effects in the same cycle as its response:
  - the fault address register receives the address;
  - the fault detail register receives bit 0 = write, bit 1 = privilege and bits `MID_W`+1:2 = master;
  - bit `ADDR_W`-1 of the control word is set.

  Writing 1 to that bit clears it. A new fault in the same cycle as the clearing write wins.
- R10: Configuration word addresses are as follows.
  - With the top address bit 0, the low two bits select the global registers: 0 is the control word, 1 is the fault address, 2 is the fault detail and 3 is the descriptor-0 alternate register.
  - With the top address bit 1, the middle bits give the descriptor number and the low two bits select the word: 0 is the lower bound, 1 the upper bound, 2 the attribute and 3 the valid flag.
  - Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration word address |
| cfg_wdata | input | ADDR_W | Configuration write data |
| cfg_rdata | output | ADDR_W | Configuration read data (combinational) |
| acc_valid | input | 1 | Access to be checked this cycle |
| acc_addr | input | ADDR_W | Access byte address |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_priv | input | 1 | 1 for supervisor, 0 for user |
| acc_mid | input | MID_W | Master number of the access |
| rsp_valid | output | 1 | Decision available |
| rsp_fault | output | 1 | Access denied |

## Verification
The hardest state to reach is a fault decision and a software clear of the error flag landing on the same clock edge. The stimulus reaches it by raising the access and the control-word write in the same half-cycle. The test then confirms that the flag stays set.

A second hard case is a descriptor that silently loses validity when one of its other words is rewritten. The bench reprograms a descriptor's attribute without rewriting its valid word. It then shows that an access the descriptor previously granted now faults.

Overlap is exercised with two descriptors that grant different privileges over a shared range. The bench issues back-to-back accesses whose outcomes differ. The scoreboard checks them in order.

// File: rtl/rg_pkg.sv
package rg_pkg;
  localparam int ATTR_W      = 6;
  localparam int CORE_ATTR_W = 4;
  localparam int BIT_DBG_RD  = 4;
  localparam int BIT_DBG_WR  = 5;

  typedef enum logic [1:0] {
    WD_LOW   = 2'd0,
    WD_HIGH  = 2'd1,
    WD_ATTR  = 2'd2,
    WD_VALID = 2'd3
  } dword_e;

  typedef enum logic [1:0] {
    GR_CTRL     = 2'd0,
    GR_ERR_ADDR = 2'd1,
    GR_ERR_INFO = 2'd2,
    GR_ALT0     = 2'd3
  } greg_e;
endpackage

// File: rtl/rg_desc_file.sv
module rg_desc_file
  import rg_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int N_DESC    = 8,
  parameter int GRAN_LOG2 = 5,
  localparam int IDX_W    = $clog2(N_DESC)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  dword_e                   wr_word,
  input  logic [ADDR_W-1:0]        wr_data,
  input  logic                     alt_wr,
  output logic [ADDR_W-1:0]        low_o  [N_DESC],
  output logic [ADDR_W-1:0]        high_o [N_DESC],
  output logic [ATTR_W-1:0]        attr_o [N_DESC],
  output logic [N_DESC-1:0]        valid_o
);
  localparam logic [ADDR_W-1:0] GMASK = (ADDR_W'(1) << GRAN_LOG2) - ADDR_W'(1);

  for (genvar gi = 0; gi < N_DESC; gi++) begin : g_desc
    if (gi == 0) begin : g_locked
      logic [CORE_ATTR_W-1:0] core_q, core_d;

      always_comb begin
        core_d = core_q;
        if (alt_wr) core_d = wr_data[CORE_ATTR_W-1:0];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      core_q <= '1;
        else if (alt_wr) core_q <= core_d;
      end

      assign low_o[gi]   = '0;
      assign high_o[gi]  = '1;
      assign attr_o[gi]  = {2'b11, core_q};
      assign valid_o[gi] = 1'b1;
    end else begin : g_open
      logic [ADDR_W-1:0] lo_q, lo_d, hi_q, hi_d;
      logic [ATTR_W-1:0] at_q, at_d;
      logic              vl_q, vl_d;
      logic              sel;

      assign sel = wr_en && (wr_idx == IDX_W'(gi));

      always_comb begin
        lo_d = lo_q;
        hi_d = hi_q;
        at_d = at_q;
        vl_d = vl_q;
        unique case (wr_word)
          WD_LOW:   begin lo_d = wr_data & ~GMASK;         vl_d = 1'b0; end
          WD_HIGH:  begin hi_d = wr_data | GMASK;          vl_d = 1'b0; end
          WD_ATTR:  begin at_d = wr_data[ATTR_W-1:0];      vl_d = 1'b0; end
          WD_VALID: begin vl_d = wr_data[0];                            end
          default:  ;
        endcase
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lo_q <= '0;
          hi_q <= '0;
          at_q <= '0;
          vl_q <= 1'b0;
        end else if (sel) begin
          lo_q <= lo_d;
          hi_q <= hi_d;
          at_q <= at_d;
          vl_q <= vl_d;
        end
      end

      // R5: rewriting a bound or the attribute leaves the descriptor invalid
      p_word_write_clears_valid_r5: assert property (
        @(posedge clk) disable iff (!rst_n)
        (sel && wr_word != WD_VALID) |=> !valid_o[gi]);

      assign low_o[gi]   = lo_q;
      assign high_o[gi]  = hi_q;
      assign attr_o[gi]  = at_q;
      assign valid_o[gi] = vl_q;
    end
  end
endmodule

// File: rtl/rg_match.sv
module rg_match
  import rg_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int N_DESC  = 8,
  parameter int MID_W   = 2,
  parameter int DBG_MID = 3
) (
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  input  logic              acc_priv,
  input  logic [MID_W-1:0]  acc_mid,
  input  logic [ADDR_W-1:0] low_i  [N_DESC],
  input  logic [ADDR_W-1:0] high_i [N_DESC],
  input  logic [ATTR_W-1:0] attr_i [N_DESC],
  input  logic [N_DESC-1:0] valid_i,
  output logic              allow_o
);
  logic [2:0]        perm_bit;
  logic [N_DESC-1:0] hit_vec;

  always_comb begin
    if (acc_mid == MID_W'(DBG_MID))
      perm_bit = acc_write ? 3'(BIT_DBG_WR) : 3'(BIT_DBG_RD);
    else
      perm_bit = {1'b0, acc_priv, acc_write};
  end

  for (genvar gi = 0; gi < N_DESC; gi++) begin : g_hit
    assign hit_vec[gi] = valid_i[gi]
                      && (acc_addr >= low_i[gi])
                      && (acc_addr <= high_i[gi])
                      && attr_i[gi][perm_bit];
  end

  assign allow_o = |hit_vec;
endmodule

// File: rtl/rg_status.sv
module rg_status #(
  parameter int ADDR_W  = 32,
  parameter int MID_W   = 2,
  localparam int INFO_W = MID_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  input  logic              acc_priv,
  input  logic [MID_W-1:0]  acc_mid,
  input  logic              allow_i,
  input  logic              ctrl_wr,
  input  logic              ctrl_en_bit,
  input  logic              ctrl_clr_bit,
  output logic              enable_o,
  output logic              status_o,
  output logic [ADDR_W-1:0] err_addr_o,
  output logic [INFO_W-1:0] err_info_o,
  output logic              rsp_valid_o,
  output logic              rsp_fault_o
);
  logic              en_q, en_d, st_q, st_d, rv_q, rf_q, deny;
  logic [ADDR_W-1:0] ea_q;
  logic [INFO_W-1:0] ei_q;

  assign deny = acc_valid && en_q && !allow_i;

  always_comb begin
    en_d = ctrl_wr ? ctrl_en_bit : en_q;
    if (deny)                       st_d = 1'b1;
    else if (ctrl_wr && ctrl_clr_bit) st_d = 1'b0;
    else                            st_d = st_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      st_q <= 1'b0;
      rv_q <= 1'b0;
      rf_q <= 1'b0;
    end else begin
      en_q <= en_d;
      st_q <= st_d;
      rv_q <= acc_valid;
      rf_q <= deny;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_q <= '0;
      ei_q <= '0;
    end else if (deny) begin
      ea_q <= acc_addr;
      ei_q <= {acc_mid, acc_priv, acc_write};
    end
  end

  assign enable_o    = en_q;
  assign status_o    = st_q;
  assign err_addr_o  = ea_q;
  assign err_info_o  = ei_q;
  assign rsp_valid_o = rv_q;
  assign rsp_fault_o = rf_q;

  p_resp_latency_r8: assert property (
    @(posedge clk) disable iff (!rst_n) acc_valid |=> rsp_valid_o);
  p_fault_with_resp_r8: assert property (
    @(posedge clk) disable iff (!rst_n) rsp_fault_o |-> rsp_valid_o);
  p_fault_sets_flag_r9: assert property (
    @(posedge clk) disable iff (!rst_n) rsp_fault_o |-> status_o);
  p_disabled_grants_r2: assert property (
    @(posedge clk) disable iff (!rst_n) (acc_valid && !enable_o) |=> !rsp_fault_o);
endmodule

// File: rtl/region_guard.sv
module region_guard
  import rg_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int N_DESC    = 8,
  parameter int GRAN_LOG2 = 5,
  parameter int MID_W     = 2,
  parameter int DBG_MID   = 3,
  localparam int IDX_W    = $clog2(N_DESC),
  localparam int CFG_AW   = IDX_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  input  logic              acc_priv,
  input  logic [MID_W-1:0]  acc_mid,
  output logic              rsp_valid,
  output logic              rsp_fault
);
  localparam int INFO_W = MID_W + 2;

  logic              is_desc;
  logic [IDX_W-1:0]  sel_idx;
  dword_e            sel_word;
  greg_e             sel_greg;
  logic              desc_wr, alt_wr, ctrl_wr;

  logic [ADDR_W-1:0] low_w  [N_DESC];
  logic [ADDR_W-1:0] high_w [N_DESC];
  logic [ATTR_W-1:0] attr_w [N_DESC];
  logic [N_DESC-1:0] valid_w;
  logic              allow;
  logic              enable, status;
  logic [ADDR_W-1:0] err_addr;
  logic [INFO_W-1:0] err_info;

  assign is_desc  = cfg_addr[CFG_AW-1];
  assign sel_idx  = cfg_addr[IDX_W+1:2];
  assign sel_word = dword_e'(cfg_addr[1:0]);
  assign sel_greg = greg_e'(cfg_addr[1:0]);
  assign desc_wr  = cfg_wr && is_desc;
  assign alt_wr   = cfg_wr && !is_desc && (sel_greg == GR_ALT0);
  assign ctrl_wr  = cfg_wr && !is_desc && (sel_greg == GR_CTRL);

  rg_desc_file #(
    .ADDR_W(ADDR_W), .N_DESC(N_DESC), .GRAN_LOG2(GRAN_LOG2)
  ) u_desc (
    .clk(clk), .rst_n(rst_n),
    .wr_en(desc_wr), .wr_idx(sel_idx), .wr_word(sel_word),
    .wr_data(cfg_wdata), .alt_wr(alt_wr),
    .low_o(low_w), .high_o(high_w), .attr_o(attr_w), .valid_o(valid_w)
  );

  rg_match #(
    .ADDR_W(ADDR_W), .N_DESC(N_DESC), .MID_W(MID_W), .DBG_MID(DBG_MID)
  ) u_match (
    .acc_addr(acc_addr), .acc_write(acc_write), .acc_priv(acc_priv),
    .acc_mid(acc_mid), .low_i(low_w), .high_i(high_w), .attr_i(attr_w),
    .valid_i(valid_w), .allow_o(allow)
  );

  rg_status #(
    .ADDR_W(ADDR_W), .MID_W(MID_W)
  ) u_status (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_write(acc_write),
    .acc_priv(acc_priv), .acc_mid(acc_mid), .allow_i(allow),
    .ctrl_wr(ctrl_wr), .ctrl_en_bit(cfg_wdata[0]),
    .ctrl_clr_bit(cfg_wdata[ADDR_W-1]),
    .enable_o(enable), .status_o(status),
    .err_addr_o(err_addr), .err_info_o(err_info),
    .rsp_valid_o(rsp_valid), .rsp_fault_o(rsp_fault)
  );

  always_comb begin
    cfg_rdata = '0;
    if (is_desc) begin
      if (int'(sel_idx) < N_DESC) begin
        unique case (sel_word)
          WD_LOW:   cfg_rdata = low_w[sel_idx];
          WD_HIGH:  cfg_rdata = high_w[sel_idx];
          WD_ATTR:  cfg_rdata = ADDR_W'(attr_w[sel_idx]);
          WD_VALID: cfg_rdata = ADDR_W'(valid_w[sel_idx]);
          default:  cfg_rdata = '0;
        endcase
      end
    end else begin
      unique case (sel_greg)
        GR_CTRL: begin
          cfg_rdata[ADDR_W-1] = status;
          cfg_rdata[0]        = enable;
        end
        GR_ERR_ADDR: cfg_rdata = err_addr;
        GR_ERR_INFO: cfg_rdata = ADDR_W'(err_info);
        GR_ALT0:     cfg_rdata = ADDR_W'(attr_w[0]);
        default:     cfg_rdata = '0;
      endcase
    end
  end

  // R6: the debugger master keeps access whatever software programs
  p_debugger_kept_r6: assert property (
    @(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_mid == MID_W'(DBG_MID)) |=> !rsp_fault);
endmodule

// File: tb/test_region_guard.sv
module test_region_guard;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int CFG_AW = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_wr = 1'b0;
  logic [CFG_AW-1:0] cfg_addr = '0;
  logic [ADDR_W-1:0] cfg_wdata = '0;
  logic [ADDR_W-1:0] cfg_rdata;
  logic              acc_valid = 1'b0;
  logic [ADDR_W-1:0] acc_addr = '0;
  logic              acc_write = 1'b0;
  logic              acc_priv = 1'b0;
  logic [1:0]        acc_mid = '0;
  logic              rsp_valid, rsp_fault;

  int nchecks = 0;
  int nerr    = 0;
  bit    exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  region_guard i_region_guard (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_write(acc_write), .acc_priv(acc_priv),
    .acc_mid(acc_mid), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault)
  );

  task automatic check_val(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [CFG_AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [CFG_AW-1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cfg_addr = a;
    #1;
    check_val(tag, cfg_rdata, exp);
  endtask

  // driver: call at a falling edge; leaves the next falling edge with acc_valid low
  task automatic acc(input logic [31:0] a, input bit w, input bit p, input logic [1:0] m,
                     input bit fault, input string tag);
    acc_addr = a; acc_write = w; acc_priv = p; acc_mid = m; acc_valid = 1'b1;
    exp_q.push_back(fault);
    tag_q.push_back(tag);
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        nchecks++; nerr++;
        $display("FAIL R8 unexpected response actual=1 expected=0");
      end else begin
        automatic bit    e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check_val(t, {31'b0, rsp_fault}, {31'b0, e});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R10 map
    rd_chk(6'd0,  32'h0,        "R1 ctrl");
    rd_chk(6'd1,  32'h0,        "R1 err addr");
    rd_chk(6'd2,  32'h0,        "R1 err info");
    rd_chk(6'd32, 32'h0,        "R1 d0 low");
    rd_chk(6'd33, 32'hFFFFFFFF, "R1 d0 high");
    rd_chk(6'd34, 32'h3F,       "R1 d0 attr");
    rd_chk(6'd35, 32'h1,        "R1 d0 valid");
    rd_chk(6'd36, 32'h0,        "R1 d1 low");
    rd_chk(6'd39, 32'h0,        "R1 d1 valid");

    // R6 alternate register, R2 disabled grants
    wr(6'd3, 32'h0);
    rd_chk(6'd34, 32'h30, "R6 alt clears core bits");
    rd_chk(6'd3,  32'h30, "R10 alt readback");
    @(negedge clk);
    acc(32'h1000, 1'b0, 1'b0, 2'd0, 1'b0, "R2 disabled grant");
    wr(6'd0, 32'h1);
    rd_chk(6'd0, 32'h1, "R2 enable bit");
    @(negedge clk);
    acc(32'h1000, 1'b0, 1'b0, 2'd0, 1'b1, "R3 no region grants");
    rd_chk(6'd1, 32'h1000,     "R9 err addr");
    rd_chk(6'd2, 32'h0,        "R9 err info user read");
    rd_chk(6'd0, 32'h80000001, "R9 flag set");
    @(negedge clk);
    acc(32'h44, 1'b1, 1'b0, 2'd3, 1'b0, "R6 debugger write granted");
    acc(32'h80000040, 1'b1, 1'b1, 2'd1, 1'b1, "R4 supervisor write denied");
    rd_chk(6'd1, 32'h80000040, "R9 err addr latest");
    rd_chk(6'd2, 32'h7,        "R9 err info sup write m1");
    wr(6'd0, 32'h80000001);
    rd_chk(6'd0, 32'h1, "R9 w1c clears flag");

    // R6 descriptor 0 words locked
    wr(6'd32, 32'h100);
    wr(6'd33, 32'h0);
    wr(6'd34, 32'h3F);
    wr(6'd35, 32'h0);
    rd_chk(6'd32, 32'h0,        "R6 d0 low locked");
    rd_chk(6'd33, 32'hFFFFFFFF, "R6 d0 high locked");
    rd_chk(6'd34, 32'h30,       "R6 d0 attr locked");
    rd_chk(6'd35, 32'h1,        "R6 d0 valid locked");
    wr(6'd3, 32'hF3);
    rd_chk(6'd34, 32'h33, "R6 alt writes low bits only");
    rd_chk(6'd35, 32'h1,  "R6 alt keeps valid");
    wr(6'd3, 32'h0);

    // R5 / R7 descriptor 1
    wr(6'd39, 32'h1);
    rd_chk(6'd39, 32'h1, "R5 valid set");
    wr(6'd36, 32'h2003);
    rd_chk(6'd36, 32'h2000, "R7 low aligned");
    rd_chk(6'd39, 32'h0,    "R5 low write clears valid");
    wr(6'd37, 32'h2FF0);
    rd_chk(6'd37, 32'h2FFF, "R7 high aligned");
    wr(6'd38, 32'h1);
    wr(6'd39, 32'h1);

    // R3 / R4 boundaries, back-to-back
    @(negedge clk);
    acc(32'h2000, 1'b0, 1'b0, 2'd0, 1'b0, "R3 low bound inclusive");
    acc(32'h2FFF, 1'b0, 1'b0, 2'd0, 1'b0, "R3 high bound inclusive");
    acc(32'h3000, 1'b0, 1'b0, 2'd0, 1'b1, "R3 above high bound");
    acc(32'h1FFF, 1'b0, 1'b0, 2'd0, 1'b1, "R3 below low bound");
    acc(32'h2100, 1'b1, 1'b0, 2'd0, 1'b1, "R4 user write denied");
    acc(32'h2100, 1'b0, 1'b1, 2'd0, 1'b1, "R4 supervisor read denied");

    // R3 overlap OR with descriptor 2 (supervisor rw)
    wr(6'd40, 32'h2800);
    wr(6'd41, 32'h28FF);
    wr(6'd42, 32'hC);
    wr(6'd43, 32'h1);
    @(negedge clk);
    acc(32'h2810, 1'b1, 1'b1, 2'd0, 1'b0, "R3 overlap sup write");
    acc(32'h2900, 1'b1, 1'b1, 2'd0, 1'b1, "R3 outside inner region");
    acc(32'h2810, 1'b0, 1'b0, 2'd0, 1'b0, "R3 overlap user read");
    acc(32'h2810, 1'b1, 1'b0, 2'd0, 1'b1, "R3 overlap user write");

    // R5 attribute rewrite invalidates
    wr(6'd42, 32'hF);
    rd_chk(6'd43, 32'h0, "R5 attr write clears valid");
    @(negedge clk);
    acc(32'h2810, 1'b1, 1'b1, 2'd0, 1'b1, "R5 invalid region ignored");

    // R9 set wins over simultaneous clear
    wr(6'd0, 32'h80000001);
    rd_chk(6'd0, 32'h1, "R9 flag cleared");
    @(negedge clk);
    acc_addr = 32'h5000; acc_write = 1'b1; acc_priv = 1'b0; acc_mid = 2'd0;
    acc_valid = 1'b1;
    exp_q.push_back(1'b1);
    tag_q.push_back("R9 fault during clear");
    cfg_addr = 6'd0; cfg_wdata = 32'h80000001; cfg_wr = 1'b1;
    @(negedge clk);
    acc_valid = 1'b0; cfg_wr = 1'b0;
    rd_chk(6'd0, 32'h80000001, "R9 set wins over clear");

    // R2 disable again
    wr(6'd0, 32'h0);
    rd_chk(6'd0, 32'h80000000, "R2 disable keeps flag");
    @(negedge clk);
    acc(32'h5000, 1'b1, 1'b0, 2'd0, 1'b0, "R2 disabled grant again");

    repeat (2) @(negedge clk);
    nchecks++;
    if (exp_q.size() != 0) begin
      nerr++;
      $display("FAIL R8 missing responses actual=%0d expected=0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", nerr, nchecks);
    $finish;
  end
endmodule